// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block erases a byte range of a page-organised serial flash without processor help. A single `start` pulse hands it a byte offset, a byte length and a page-address shift. It first checks that the offset and the length are both whole multiples of the page size. It then walks the range one erase step at a time. A step erases an eight-page block when the current page index is block-aligned and at least a block remains. Otherwise it erases one page.

Each step sends a four-byte command frame through a byte-level request/acknowledge port. The port's owner shifts the bytes out over SPI and frames chip select. The sequencer then polls the device with two-byte status frames until the ready bit is set. A fixed idle gap separates consecutive polls, and a cycle-counted window bounds the wait. The device address in a frame is the page index shifted left by the configured amount, not a linear byte address. At the end `done` pulses with an error code.

Top module: `esq_erase_seq`

## Requirements
- R1: If the length or the start offset is not an exact multiple of PAGE_BYTES, the operation ends with `err_code` = 1 and no byte request is ever raised.
- R2: A step uses opcode 0x50 (block erase, 8 pages) when the current page index has its low three bits zero and at least 8 pages remain; otherwise it uses opcode 0x81 (page erase).
- R3: A command frame is four bytes in this order: opcode, bits 23:16 of (page index << `page_shift`), bits 15:8 of that address, then 0x00. Only the fourth byte has `spi_last` set, so chip select is released between the command frame and the first poll.
- R4: After each command frame the block sends status-poll frames of two bytes: 0xD7, then 0x00 with `spi_last` set. The device counts as ready only when bit 7 of the byte returned for the second byte is 1. The byte returned for the first byte is ignored.
- R5: After a ready poll, the page index advances and the remaining page count drops by 8 after a block erase, or by 1 after a page erase. When the count reaches zero, `done` pulses with `err_code` = 0.
- R6: After a not-ready poll, no request is raised for at least POLL_GAP cycles before the next poll frame starts.
- R7: If the device is still not ready once TIMEOUT_CYC cycles have passed since the end of a command frame, the operation ends with `err_code` = 2 and no further command frame is sent.
- R8: `busy` rises in the cycle after a `start` is accepted while idle and stays high until the cycle in which `done` pulses. `done` is a one-cycle pulse with `busy` low. After reset, `busy`, `done`, `err_code` and `spi_req` are 0.
- R9: A `start` pulse while `busy` is high is ignored. The running operation's frame sequence is unchanged.
- R10: A zero length completes with `err_code` = 0 and no byte request.
- R11: `spi_req` is raised only while `busy` is high. Once raised, it is held with stable `spi_tx` and `spi_last` until `spi_ack`. Each acknowledge consumes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase when idle |
| start_ofs | input | OFS_W | Start byte offset |
| erase_len | input | OFS_W | Length in bytes |
| page_shift | input | SHIFT_W | Left shift from page index to device address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_code | output | 2 | 0 ok, 1 misaligned, 2 timeout; valid from `done` on |
| spi_req | output | 1 | Byte request to the SPI engine |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Release chip select after this byte |
| spi_ack | input | 1 | Byte transferred, `spi_rx` valid |
| spi_rx | input | 8 | Byte received during the transfer |

## Verification
The main function is tried with several page layouts:
- A lone page, which separates page erase from block erase at the simplest level.
- An aligned eight-page range, which must produce exactly one block erase.
- A range starting mid-block and running past two block boundaries, which must produce page, block, page steps in that order.
- Seven pages starting on a block boundary, which checks the remaining-length condition on its own.
- A high page index with the widest shift, which checks the address bytes.

Devices that report not-ready a few times show the poll gap and show that the junk byte returned for the poll opcode is ignored. A device that never becomes ready separates a working timeout from a hang or an early exit. Misaligned and zero-length requests are tried to confirm that the bus stays silent.

// File: rtl/esq_pkg.sv
package esq_pkg;

  localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OPC_STATUS      = 8'hD7;
  localparam logic [7:0] STAT_READY_MASK = 8'h80;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } esq_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIV,
    S_NEXT,
    S_SEND,
    S_GAP
  } esq_state_e;

endpackage

// File: rtl/esq_divider.sv
module esq_divider #(
  parameter int W       = 24,
  parameter int DIVISOR = 264
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         valid
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W:0] DIV_C = (W+1)'(DIVISOR);

  logic [W-1:0]  acc;
  logic [W-1:0]  part;
  logic [W:0]    trial;
  logic [CW-1:0] cnt;
  logic          run;

  always_comb trial = {part, acc[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      part  <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        acc  <= dividend;
        part <= '0;
        cnt  <= CW'(W);
        run  <= 1'b1;
      end else if (run) begin
        if (trial >= DIV_C) begin
          part <= W'(trial - DIV_C);
          acc  <= {acc[W-2:0], 1'b1};
        end else begin
          part <= W'(trial);
          acc  <= {acc[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quo = acc;
  assign rem = part;
endmodule

// File: rtl/esq_frame_bytes.sv
module esq_frame_bytes
  import esq_pkg::*;
#(
  parameter int IDX_W   = 24,
  parameter int SHIFT_W = 4
) (
  input  logic [IDX_W-1:0]   page_idx,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               is_block,
  input  logic               is_poll,
  input  logic [1:0]         byte_no,
  output logic [7:0]         tx,
  output logic               last
);
  localparam int AW = IDX_W + (1 << SHIFT_W);

  logic [AW-1:0] dev_addr;
  logic [15:0]   mid16;

  assign dev_addr = AW'(page_idx) << shift;
  assign mid16    = 16'(dev_addr >> 8);

  always_comb begin
    tx   = 8'h00;
    last = 1'b0;
    if (is_poll) begin
      case (byte_no)
        2'd0:    tx = OPC_STATUS;
        default: begin tx = 8'h00; last = 1'b1; end
      endcase
    end else begin
      case (byte_no)
        2'd0:    tx = is_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;
        2'd1:    tx = mid16[15:8];
        2'd2:    tx = mid16[7:0];
        default: begin tx = 8'h00; last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/esq_poll_timer.sv
module esq_poll_timer #(
  parameter int GAP_CYC   = 6,
  parameter int LIMIT_CYC = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic win_clear,
  input  logic gap_go,
  output logic gap_done,
  output logic expired
);
  localparam int EW = $clog2(LIMIT_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [EW-1:0] elapsed;
  logic [GW-1:0] gap_cnt;
  logic          gap_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed  <= '0;
      gap_cnt  <= '0;
      gap_run  <= 1'b0;
      gap_done <= 1'b0;
    end else begin
      gap_done <= 1'b0;
      if (win_clear)
        elapsed <= '0;
      else if (elapsed != EW'(LIMIT_CYC))
        elapsed <= elapsed + 1'b1;

      if (gap_go) begin
        gap_cnt <= GW'(GAP_CYC);
        gap_run <= 1'b1;
      end else if (gap_run) begin
        if (gap_cnt <= GW'(1)) begin
          gap_run  <= 1'b0;
          gap_done <= 1'b1;
        end else begin
          gap_cnt <= gap_cnt - 1'b1;
        end
      end
    end
  end

  assign expired = (elapsed == EW'(LIMIT_CYC));
endmodule

// File: rtl/esq_erase_seq.sv
module esq_erase_seq
  import esq_pkg::*;
#(
  parameter int OFS_W       = 24,
  parameter int PAGE_BYTES  = 264,
  parameter int SHIFT_W     = 4,
  parameter int BLK_LOG2    = 3,
  parameter int POLL_GAP    = 6,
  parameter int TIMEOUT_CYC = 300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OFS_W-1:0]   start_ofs,
  input  logic [OFS_W-1:0]   erase_len,
  input  logic [SHIFT_W-1:0] page_shift,
  output logic               busy,
  output logic               done,
  output logic [1:0]         err_code,
  output logic               spi_req,
  output logic [7:0]         spi_tx,
  output logic               spi_last,
  input  logic               spi_ack,
  input  logic [7:0]         spi_rx
);
  localparam int NUM_DIV   = 2;
  localparam int BLK_PAGES = 1 << BLK_LOG2;

  esq_state_e         state;
  logic [SHIFT_W-1:0] shift_q;
  logic [OFS_W-1:0]   page_idx;
  logic [OFS_W-1:0]   pages_left;
  logic               use_blk;
  logic               poll_mode;
  logic [1:0]         byte_no;
  logic               req_q;
  logic [7:0]         tx_q;
  logic               last_q;
  logic               busy_q;
  logic               done_q;
  esq_err_e           err_q;

  // Offset and length are divided in parallel by the page size.
  logic               div_go;
  logic [OFS_W-1:0]   div_in [NUM_DIV];
  logic [OFS_W-1:0]   div_q  [NUM_DIV];
  logic [OFS_W-1:0]   div_r  [NUM_DIV];
  logic [NUM_DIV-1:0] div_v;

  assign div_go    = (state == S_IDLE) && start;
  assign div_in[0] = start_ofs;
  assign div_in[1] = erase_len;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    esq_divider #(.W(OFS_W), .DIVISOR(PAGE_BYTES)) u_div (
      .clk      (clk),
      .rst      (rst),
      .go       (div_go),
      .dividend (div_in[g]),
      .quo      (div_q[g]),
      .rem      (div_r[g]),
      .valid    (div_v[g])
    );
  end

  logic [7:0] fb_tx;
  logic       fb_last;

  esq_frame_bytes #(.IDX_W(OFS_W), .SHIFT_W(SHIFT_W)) u_frame (
    .page_idx (page_idx),
    .shift    (shift_q),
    .is_block (use_blk),
    .is_poll  (poll_mode),
    .byte_no  (byte_no),
    .tx       (fb_tx),
    .last     (fb_last)
  );

  logic ack_now, rx_ready, win_clear, poll_miss, gap_done, expired, step_blk;

  assign ack_now   = (state == S_SEND) && req_q && spi_ack;
  assign rx_ready  = (spi_rx & STAT_READY_MASK) != 8'h00;
  assign win_clear = ack_now && last_q && !poll_mode;
  assign poll_miss = ack_now && last_q && poll_mode && !rx_ready;
  assign step_blk  = (page_idx[BLK_LOG2-1:0] == '0) &&
                     (pages_left >= OFS_W'(BLK_PAGES));

  esq_poll_timer #(.GAP_CYC(POLL_GAP), .LIMIT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .win_clear (win_clear),
    .gap_go    (poll_miss),
    .gap_done  (gap_done),
    .expired   (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      shift_q    <= '0;
      page_idx   <= '0;
      pages_left <= '0;
      use_blk    <= 1'b0;
      poll_mode  <= 1'b0;
      byte_no    <= '0;
      req_q      <= 1'b0;
      tx_q       <= '0;
      last_q     <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            busy_q  <= 1'b1;
            shift_q <= page_shift;
            state   <= S_DIV;
          end
        end
        S_DIV: begin
          if (&div_v) begin
            if ((div_r[0] != '0) || (div_r[1] != '0)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              err_q  <= ERR_ALIGN;
              state  <= S_IDLE;
            end else begin
              page_idx   <= div_q[0];
              pages_left <= div_q[1];
              state      <= S_NEXT;
            end
          end
        end
        S_NEXT: begin
          if (pages_left == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= ERR_NONE;
            state  <= S_IDLE;
          end else begin
            use_blk   <= step_blk;
            poll_mode <= 1'b0;
            byte_no   <= '0;
            state     <= S_SEND;
          end
        end
        S_SEND: begin
          if (!req_q) begin
            req_q  <= 1'b1;
            tx_q   <= fb_tx;
            last_q <= fb_last;
          end else if (spi_ack) begin
            req_q <= 1'b0;
            if (last_q) begin
              byte_no <= '0;
              if (!poll_mode) begin
                poll_mode <= 1'b1;
              end else if (rx_ready) begin
                if (use_blk) begin
                  page_idx   <= page_idx + OFS_W'(BLK_PAGES);
                  pages_left <= pages_left - OFS_W'(BLK_PAGES);
                end else begin
                  page_idx   <= page_idx + 1'b1;
                  pages_left <= pages_left - 1'b1;
                end
                state <= S_NEXT;
              end else begin
                state <= S_GAP;
              end
            end else begin
              byte_no <= byte_no + 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gap_done) begin
            if (expired) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              err_q  <= ERR_TIMEOUT;
              state  <= S_IDLE;
            end else begin
              byte_no <= '0;
              state   <= S_SEND;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err_code = err_q;
  assign spi_req  = req_q;
  assign spi_tx   = tx_q;
  assign spi_last = last_q;
endmodule

// File: rtl/esq_checker.sv
module esq_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code,
  input logic       spi_req,
  input logic [7:0] spi_tx,
  input logic       spi_last,
  input logic       spi_ack
);
  logic at_frame_start;

  always_ff @(posedge clk) begin
    if (rst)
      at_frame_start <= 1'b1;
    else if (spi_req && spi_ack)
      at_frame_start <= spi_last;
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    spi_req && !spi_ack |=> spi_req && $stable(spi_tx) && $stable(spi_last));

  a_r11_req_in_op: assert property (@(posedge clk) disable iff (rst)
    spi_req |-> busy);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r2_frame_opcode: assert property (@(posedge clk) disable iff (rst)
    spi_req && at_frame_start |->
      (spi_tx == 8'h50 || spi_tx == 8'h81 || spi_tx == 8'hD7));

  a_r7_err_code_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> err_code != 2'd3);
endmodule

bind esq_erase_seq esq_checker u_chk (.*);

// File: tb/tb_esq_erase_seq.sv
module tb_esq_erase_seq;
  localparam int OFS_W   = 24;
  localparam int PAGE    = 264;
  localparam int SHIFT_W = 4;
  localparam int GAP     = 6;
  localparam int TMO     = 300;
  localparam int LAT     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [OFS_W-1:0] start_ofs = '0;
  logic [OFS_W-1:0] erase_len = '0;
  logic [SHIFT_W-1:0] page_shift = '0;
  logic busy, done, spi_req, spi_last;
  logic [1:0] err_code;
  logic [7:0] spi_tx;
  logic spi_ack = 1'b0;
  logic [7:0] spi_rx = 8'h00;

  always #10 clk = ~clk;

  esq_erase_seq #(.OFS_W(OFS_W), .PAGE_BYTES(PAGE), .SHIFT_W(SHIFT_W),
                  .BLK_LOG2(3), .POLL_GAP(GAP), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .start(start), .start_ofs(start_ofs),
    .erase_len(erase_len), .page_shift(page_shift), .busy(busy), .done(done),
    .err_code(err_code), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_last(spi_last), .spi_ack(spi_ack), .spi_rx(spi_rx));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rec[$];
  int exp_q[$];
  int nr_notready = 0;
  int min_gap = 1000000;
  int cmd_end_cyc = 0;
  int done_cyc = 0;
  bit done_seen = 1'b0;
  bit m_busy = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // SPI byte engine and flash status model
  initial begin
    int cnt, pos, polls, last_poll_end;
    logic [7:0] op;
    cnt = 0; pos = 0; polls = 0; last_poll_end = 0; op = 8'h00;
    forever begin
      @(posedge clk);
      cyc++;
      if (rst) begin
        spi_ack <= 1'b0; cnt = 0; pos = 0;
      end else if (spi_ack) begin
        spi_ack <= 1'b0; cnt = 0;
      end else if (spi_req) begin
        cnt++;
        if (cnt == LAT) begin
          spi_ack <= 1'b1;
          rec.push_back({23'd0, spi_last, spi_tx});
          if (pos == 0) begin
            op = spi_tx;
            if (spi_tx != 8'hD7) polls = 0;
            else if (polls > 0 && (cyc - last_poll_end - LAT) < min_gap)
              min_gap = cyc - last_poll_end - LAT;
          end
          if (op == 8'hD7 && pos == 1) begin
            polls++;
            spi_rx <= (polls > nr_notready) ? 8'hAC : 8'h2C;
          end else begin
            spi_rx <= 8'hFF;
          end
          if (spi_last) begin
            if (op == 8'hD7) last_poll_end = cyc;
            else cmd_end_cyc = cyc;
            pos = 0;
          end else begin
            pos++;
          end
        end
      end
    end
  end

  // Cycle reference model for busy/done
  initial begin
    bit prev_done;
    prev_done = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (done) begin
          m_busy = 1'b0;
          done_seen = 1'b1;
          done_cyc = cyc;
        end else if (!m_busy && start) begin
          m_busy = 1'b1;
        end
        chk(busy == m_busy, "R8", "busy vs model", busy, m_busy);
        if (prev_done && done) chk(1'b0, "R8", "done longer than one cycle", 1, 0);
        prev_done = done;
      end
    end
  end

  function automatic void build(int ofs, int len, int sh, int nr, ref int q[$]);
    int p, n, a;
    bit blk;
    q.delete();
    if ((ofs % PAGE) != 0 || (len % PAGE) != 0) return;
    p = ofs / PAGE;
    n = len / PAGE;
    while (n > 0) begin
      blk = ((p % 8) == 0) && (n >= 8);
      a = p << sh;
      q.push_back(blk ? 'h50 : 'h81);
      q.push_back((a >> 16) & 255);
      q.push_back((a >> 8) & 255);
      q.push_back(256);
      for (int i = 0; i <= nr; i++) begin
        q.push_back('hD7);
        q.push_back(256);
      end
      if (blk) begin p += 8; n -= 8; end
      else begin p += 1; n -= 1; end
    end
  endfunction

  task automatic launch(int ofs, int len, int sh, int nr, bit extra);
    int n;
    rec.delete();
    nr_notready = nr;
    done_seen = 1'b0;
    min_gap = 1000000;
    @(negedge clk);
    start_ofs = OFS_W'(ofs); erase_len = OFS_W'(len);
    page_shift = SHIFT_W'(sh); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra) begin
      repeat (40) @(negedge clk);
      start_ofs = '0; erase_len = OFS_W'(8 * PAGE); page_shift = 4'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done_seen && n < 50000) begin @(negedge clk); n++; end
    chk(done_seen, "R8", "done seen", done_seen, 1);
  endtask

  task automatic run_op(string req, int ofs, int len, int sh, int nr, int exp_err, bit extra);
    int mism, sz;
    build(ofs, len, sh, nr, exp_q);
    launch(ofs, len, sh, nr, extra);
    chk(err_code == 2'(exp_err), req, "err_code", err_code, exp_err);
    mism = 0;
    if (rec.size() == exp_q.size())
      foreach (exp_q[i]) if (rec[i] != exp_q[i]) mism++;
    chk(rec.size() == exp_q.size(), req, "frame byte count", rec.size(), exp_q.size());
    chk(mism == 0, req, "frame byte mismatches", mism, 0);
    sz = rec.size();
    repeat (20) @(negedge clk);
    chk(rec.size() == sz, req, "no bytes after done", rec.size(), sz);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "reset busy", busy, 0);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    chk(err_code == 2'd0, "R8", "reset err_code", err_code, 0);
    chk(spi_req == 1'b0, "R11", "reset spi_req", spi_req, 0);

    run_op("R10", 5 * PAGE, 0, 9, 0, 0, 0);
    run_op("R1", 0, PAGE + 1, 9, 0, 1, 0);
    run_op("R1", 2 * PAGE + 4, PAGE, 9, 0, 1, 0);
    run_op("R3", 3 * PAGE, PAGE, 9, 0, 0, 0);
    run_op("R2", 0, 8 * PAGE, 9, 0, 0, 0);
    run_op("R5", 5 * PAGE, 13 * PAGE, 10, 2, 0, 0);
    chk(min_gap >= GAP, "R6", "idle cycles between polls", min_gap, GAP);
    run_op("R2", 8 * PAGE, 7 * PAGE, 9, 1, 0, 0);
    run_op("R3", 4000 * PAGE, 8 * PAGE, 11, 0, 0, 0);
    run_op("R9", 5 * PAGE, 13 * PAGE, 10, 1, 0, 1);
    run_op("R4", 16 * PAGE, 2 * PAGE, 9, 3, 0, 0);

    begin : timeout_case
      int mism, polls, span;
      build(0, 2 * PAGE, 9, 0, exp_q);
      launch(0, 2 * PAGE, 9, 1000000, 0);
      chk(err_code == 2'd2, "R7", "timeout err_code", err_code, 2);
      mism = 0;
      for (int i = 0; i < 4; i++) if (rec.size() <= i || rec[i] != exp_q[i]) mism++;
      for (int i = 4; i < rec.size(); i++)
        if (rec[i] != (((i % 2) == 0) ? 'hD7 : 256)) mism++;
      chk(mism == 0, "R7", "only one command then polls", mism, 0);
      polls = (rec.size() - 4) / 2;
      chk(polls >= 2, "R7", "poll frames before timeout", polls, 2);
      span = done_cyc - cmd_end_cyc;
      chk(span >= TMO && span <= TMO + GAP + 30, "R7", "timeout span", span, TMO);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule